// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block models a word-organized serial EEPROM behind a three-wire select/clock/data interface. The host raises chip select and shifts bits in on data-in, one per rising edge of the serial clock. Each command is a start bit of 1, then a two-bit opcode, then a word address sent most significant bit first. Opcode 00 is an extended group in which the two top address bits choose the action. Reads return a dummy 0 bit followed by the data word. Writes, single-word erase, erase-all and write-all change the array only while the write-enable latch is set. Each of them runs a self-timed programming cycle, counted on the system clock, which starts once chip select falls. While chip select is low, data-out is released (`do_en` low).

The serial lines pass through a two-stage synchronizer, and the FSM acts on detected serial-clock rising edges. The FSM states are:
- ST_IDLE: waits for the start bit.
- ST_OPC: takes the two opcode bits.
- ST_ADR: takes the address bits and decodes the command.
- ST_DAT: takes the data word.
- ST_RD: shifts read data out.
- ST_ARM: a programming command is accepted and waits for chip select to fall.
- ST_PROG: the self-timed cycle.
- ST_RDY: the cycle is done and chip select is still high.
- ST_HOLD: a finished or refused command waits for deselect.

The transitions are:
- IDLE→OPC on a 1 bit.
- OPC→ADR after two bits.
- ADR→RD, DAT, ARM or HOLD by opcode and write enable.
- DAT→ARM, or DAT→HOLD when writes are disabled.
- ARM→PROG on deselect.
- PROG→RDY or IDLE when the count expires, depending on select.
- Every shifting state returns to IDLE on deselect.

Top module: `mw_eeprom`

## Requirements
- R1: With chip select high, 0 bits before the first 1 are ignored. That 1 is the start bit. The next two bits are the opcode, followed by ADDR_W address bits, MSB first.
- R2: READ (opcode 10) drives a 0 dummy bit after the last address bit. It then presents the DATA_W-bit word MSB first, advancing one bit per serial-clock rising edge. This works whether writes are enabled or not.
- R3: WRITE (opcode 01) takes an address and then DATA_W data bits. The word is stored by a programming cycle that starts when chip select falls.
- R4: ERASE (opcode 11) sets every bit of the addressed word to 1.
- R5: ERAL (opcode 00, top address bits 10) sets every word to all ones.
- R6: WRAL (opcode 00, top address bits 01, then DATA_W data bits) writes the data word to every location, whatever the prior contents.
- R7: EWEN (00 with top bits 11) sets the write-enable latch, and EWDS (00 with top bits 00) clears it. Reset leaves it clear. While it is clear, WRITE, ERASE, ERAL and WRAL change nothing and start no busy cycle.
- R8: A programming cycle lasts exactly PROG_CYCLES system clocks. During it, a raised chip select drives data-out low (busy). After it ends, data-out is driven high (ready) until chip select falls.
- R9: With chip select low, data-out is not driven. A command cut short by chip select falling has no effect.
- R10: Serial activity during a programming cycle, including EWDS, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; times the programming cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock; data is taken on its rising edge |
| di | input | 1 | Serial data in |
| do_out | output | 1 | Serial data out / busy-ready level |
| do_en | output | 1 | Output drive enable; low means high impedance |

## Verification
The bench builds the block with ADDR_W = 4 (16 words), DATA_W = 16 and PROG_CYCLES = 24. With that small array, erase-all and write-all can be confirmed by reading back every word. A short cycle count lets busy, ready and the command-during-busy case all occur within one command's length. Random writes, erases and reads of a reference array run after directed checks of the disabled latch, leading zeros and aborted commands.

// File: rtl/mw_pkg.sv
package mw_pkg;

    localparam logic [1:0] OPC_EXT   = 2'b00;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_ERASE = 2'b11;

    localparam logic [1:0] EXT_WDIS  = 2'b00;
    localparam logic [1:0] EXT_WALL  = 2'b01;
    localparam logic [1:0] EXT_EALL  = 2'b10;
    localparam logic [1:0] EXT_WEN   = 2'b11;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADR,
        ST_DAT,
        ST_RD,
        ST_ARM,
        ST_PROG,
        ST_RDY,
        ST_HOLD
    } mw_state_t;

endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg[g] <= '0;
            end else begin
                stg[g] <= (g == 0) ? d : stg[(g == 0) ? 0 : g - 1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/mw_store.sv
module mw_store #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
    import mw_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 2048,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic do_out,
    output logic do_en
);
    // PROG_CYCLES must be at least the word count: bulk commands walk the array.
    localparam int DEPTH   = 1 << ADDR_W;
    localparam int MAX_AD  = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
    localparam int CNT_MAX = (PROG_CYCLES > MAX_AD) ? PROG_CYCLES : MAX_AD;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    localparam logic [CNT_W-1:0] OPC_LAST  = CNT_W'(1);
    localparam logic [CNT_W-1:0] ADR_LAST  = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] DAT_LAST  = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] PROG_LAST = CNT_W'(PROG_CYCLES - 1);
    localparam logic [CNT_W-1:0] DEPTH_C   = CNT_W'(DEPTH);

    // synchronized serial lines
    logic [2:0] sync_q;
    logic       cs_s, sk_s, di_s, sk_q, sk_rise;

    mw_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({cs, sk, di}),
        .q    (sync_q)
    );

    assign {cs_s, sk_s, di_s} = sync_q;
    assign sk_rise = sk_s & ~sk_q & cs_s;

    // state and datapath registers
    mw_state_t         state, state_n;
    logic [CNT_W-1:0]  cnt;
    logic [1:0]        opc;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wsr;
    logic [DATA_W-1:0] rsr;
    logic              rbit;
    logic              wen_q;
    logic              bulk;

    logic [ADDR_W-1:0] addr_n;
    logic [1:0]        ext;
    logic              adr_done, dat_done, prog_done;

    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [DATA_W-1:0] mem_rdata;
    logic              busy_w;

    assign addr_n    = {addr[ADDR_W-2:0], di_s};
    assign ext       = addr_n[ADDR_W-1 -: 2];
    assign adr_done  = sk_rise && (cnt == ADR_LAST);
    assign dat_done  = sk_rise && (cnt == DAT_LAST);
    assign prog_done = (cnt == PROG_LAST);

    mw_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk  (clk),
        .we   (mem_we),
        .waddr(mem_waddr),
        .wdata(wsr),
        .raddr(addr_n),
        .rdata(mem_rdata)
    );

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: if (sk_rise && di_s) state_n = ST_OPC;
            ST_OPC: begin
                if (!cs_s) state_n = ST_IDLE;
                else if (sk_rise && cnt == OPC_LAST) state_n = ST_ADR;
            end
            ST_ADR: begin
                if (!cs_s) begin
                    state_n = ST_IDLE;
                end else if (adr_done) begin
                    unique case (opc)
                        OPC_READ:  state_n = ST_RD;
                        OPC_WRITE: state_n = ST_DAT;
                        OPC_ERASE: state_n = wen_q ? ST_ARM : ST_HOLD;
                        default: begin
                            if (ext == EXT_WALL)      state_n = ST_DAT;
                            else if (ext == EXT_EALL) state_n = wen_q ? ST_ARM : ST_HOLD;
                            else                      state_n = ST_HOLD;
                        end
                    endcase
                end
            end
            ST_DAT: begin
                if (!cs_s) state_n = ST_IDLE;
                else if (dat_done) state_n = wen_q ? ST_ARM : ST_HOLD;
            end
            ST_RD:   if (!cs_s) state_n = ST_IDLE;
            ST_ARM:  if (!cs_s) state_n = ST_PROG;
            ST_PROG: if (prog_done) state_n = cs_s ? ST_RDY : ST_IDLE;
            ST_RDY:  if (!cs_s) state_n = ST_IDLE;
            ST_HOLD: if (!cs_s) state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sk_q  <= 1'b0;
            cnt   <= '0;
            opc   <= '0;
            addr  <= '0;
            wsr   <= '0;
            rsr   <= '0;
            rbit  <= 1'b0;
            wen_q <= 1'b0;
            bulk  <= 1'b0;
        end else begin
            sk_q <= sk_s;

            if (state_n != state)       cnt <= '0;
            else if (state == ST_PROG)  cnt <= cnt + 1'b1;
            else if (sk_rise)           cnt <= cnt + 1'b1;

            unique case (state)
                ST_OPC: if (sk_rise) opc <= {opc[0], di_s};
                ST_ADR: begin
                    if (sk_rise) addr <= addr_n;
                    if (adr_done && cs_s) begin
                        bulk <= (opc == OPC_EXT);
                        if (opc == OPC_READ) begin
                            rsr  <= mem_rdata;
                            rbit <= 1'b0;
                        end
                        if (opc == OPC_ERASE || (opc == OPC_EXT && ext == EXT_EALL)) begin
                            wsr <= '1;
                        end
                        if (opc == OPC_EXT && ext == EXT_WEN)  wen_q <= 1'b1;
                        if (opc == OPC_EXT && ext == EXT_WDIS) wen_q <= 1'b0;
                    end
                end
                ST_DAT: if (sk_rise) wsr <= {wsr[DATA_W-2:0], di_s};
                ST_RD: begin
                    if (sk_rise) begin
                        rbit <= rsr[DATA_W-1];
                        rsr  <= {rsr[DATA_W-2:0], 1'b0};
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs and array write port
    always_comb begin
        busy_w    = (state == ST_PROG);
        mem_we    = 1'b0;
        mem_waddr = addr;
        if (busy_w) begin
            if (bulk) begin
                mem_we    = (cnt < DEPTH_C);
                mem_waddr = cnt[ADDR_W-1:0];
            end else begin
                mem_we    = (cnt == '0);
            end
        end
        do_en  = cs_s && (state == ST_RD || state == ST_PROG || state == ST_RDY);
        do_out = (state == ST_RD) ? rbit : (state == ST_RDY);
    end

endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk #(
    parameter int PROG_CYCLES = 2048
) (
    input logic clk,
    input logic rst_n,
    input logic cs,
    input logic do_en,
    input logic do_out,
    input logic busy,
    input logic wen,
    input logic mem_we
);
    int unsigned run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_len <= 0;
        else if (busy) run_len <= run_len + 1;
        else           run_len <= 0;
    end

    a_r8_busy_low: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && do_en) |-> !do_out);

    a_r8_cycle_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == PROG_CYCLES));

    a_r7_write_gated: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wen);

    a_r9_released: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs && !$past(cs) && !$past(cs, 2) && !$past(cs, 3)) |-> !do_en);

    a_r10_enable_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(wen));

endmodule

bind mw_eeprom mw_eeprom_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cs    (cs),
    .do_en (do_en),
    .do_out(do_out),
    .busy  (busy_w),
    .wen   (wen_q),
    .mem_we(mem_we)
);

// File: tb/test_mw_eeprom.sv
module test_mw_eeprom;
    localparam int AW   = 4;
    localparam int DW   = 16;
    localparam int PROG = 24;
    localparam int HALF = 4;
    localparam int NW   = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0;
    logic do_out, do_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [DW-1:0] model [NW];

    always #10 clk = ~clk;

    mw_eeprom #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYCLES(PROG)) i_mw_eeprom (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
        .do_out(do_out), .do_en(do_en)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sbit(input logic b);
        di = b;
        wclk(HALF);
        sk = 1'b1;
        wclk(HALF);
        sk = 1'b0;
    endtask

    task automatic head(input logic [1:0] op, input logic [AW-1:0] a, input int zeros);
        cs = 1'b1;
        wclk(HALF);
        for (int i = 0; i < zeros; i++) sbit(1'b0);
        sbit(1'b1);
        sbit(op[1]);
        sbit(op[0]);
        for (int i = AW - 1; i >= 0; i--) sbit(a[i]);
    endtask

    task automatic deselect();
        cs = 1'b0;
        di = 1'b0;
        wclk(HALF);
    endtask

    function automatic logic [AW-1:0] ext_addr(input logic [1:0] sel);
        return {sel, {(AW-2){1'b0}}};
    endfunction

    // programming command; runs says whether a busy cycle is expected
    task automatic prog(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input bit has_d, input bit runs, input string req);
        head(op, a, 0);
        if (has_d) for (int i = DW - 1; i >= 0; i--) sbit(d[i]);
        cs = 1'b0;
        di = 1'b0;
        wclk(2);
        cs = 1'b1;
        wclk(4);
        if (runs) begin
            chk(do_en && !do_out, {req, " busy low (R8)"}, {do_en, do_out}, 2'b10);
            wclk(PROG + 8);
            chk(do_en && do_out, {req, " ready high (R8)"}, {do_en, do_out}, 2'b11);
        end else begin
            chk(!do_en, {req, " no busy cycle (R7)"}, do_en, 0);
        end
        deselect();
        chk(!do_en, "R9 released after deselect", do_en, 0);
    endtask

    task automatic rd(input logic [AW-1:0] a, input int zeros, output logic [DW-1:0] v, output logic dummy_ok);
        head(2'b10, a, zeros);
        dummy_ok = do_en && !do_out;
        v = '0;
        for (int i = 0; i < DW; i++) begin
            di = 1'b0;
            wclk(HALF);
            sk = 1'b1;
            wclk(HALF);
            v = {v[DW-2:0], do_out};
            sk = 1'b0;
        end
        deselect();
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input string req);
        logic [DW-1:0] v;
        logic dok;
        rd(a, 0, v, dok);
        chk(dok, "R2 dummy bit", {31'd0, dok}, 1);
        chk(v === model[a], req, v, model[a]);
    endtask

    task automatic send_ext(input logic [1:0] sel);
        head(2'b00, ext_addr(sel), 0);
        deselect();
    endtask

    initial begin
        int unused_seed;
        logic [DW-1:0] v;
        logic dok;
        unused_seed = $urandom(32'd1234);

        wclk(5);
        rst_n = 1'b1;
        wclk(4);
        chk(!do_en, "R9 reset state released", do_en, 0);

        // R7: disabled after reset, programming refused
        prog(2'b00, ext_addr(2'b10), '0, 0, 0, "R7 ERAL while disabled");

        send_ext(2'b11);
        prog(2'b00, ext_addr(2'b10), '0, 0, 1, "R5 ERAL");
        for (int i = 0; i < NW; i++) model[i] = '1;
        for (int i = 0; i < NW; i++) rd_chk(AW'(i), "R5 erase all ones");

        // R6: write-all over erased contents
        prog(2'b00, ext_addr(2'b01), 16'hA5C3, 1, 1, "R6 WRAL");
        for (int i = 0; i < NW; i++) model[i] = 16'hA5C3;
        for (int i = 0; i < NW; i++) rd_chk(AW'(i), "R6 write all");

        // R3: single writes at both ends
        prog(2'b01, 0, 16'h0000, 1, 1, "R3 WRITE");
        model[0] = 16'h0000;
        prog(2'b01, AW'(NW - 1), 16'h8001, 1, 1, "R3 WRITE");
        model[NW-1] = 16'h8001;
        rd_chk(0, "R3 write low address");
        rd_chk(AW'(NW - 1), "R3 write high address");

        // R4: erase single word
        prog(2'b11, 0, '0, 0, 1, "R4 ERASE");
        model[0] = '1;
        rd_chk(0, "R4 erased word");
        rd_chk(1, "R4 neighbour untouched");

        // R1: leading zeros before the start bit
        rd(AW'(NW - 1), 3, v, dok);
        chk(v === model[NW-1], "R1 leading zeros ignored", v, model[NW-1]);

        // R10: EWDS shifted during a busy cycle is ignored
        head(2'b01, 5, 0);
        for (int i = DW - 1; i >= 0; i--) sbit(model[0][i] ^ (i == 3));
        model[5] = 16'hFFF7;
        cs = 1'b0;
        wclk(2);
        head(2'b00, ext_addr(2'b00), 0);
        deselect();
        prog(2'b01, 6, 16'h4321, 1, 1, "R10 enable kept after busy EWDS");
        model[6] = 16'h4321;
        rd_chk(5, "R10 write before busy command");
        rd_chk(6, "R10 write after busy command");

        // R9: aborted command has no effect
        cs = 1'b1;
        wclk(HALF);
        sbit(1'b1); sbit(1'b0); sbit(1'b1); sbit(1'b0); sbit(1'b1);
        deselect();
        rd_chk(7, "R9 aborted write no effect");

        // R7: disabled again, all programming refused; R2 read still works
        send_ext(2'b00);
        prog(2'b01, 2, 16'h1111, 1, 0, "R7 WRITE disabled");
        prog(2'b11, 2, '0, 0, 0, "R7 ERASE disabled");
        prog(2'b00, ext_addr(2'b01), 16'h2222, 1, 0, "R7 WRAL disabled");
        prog(2'b00, ext_addr(2'b10), '0, 0, 0, "R7 ERAL disabled");
        rd_chk(2, "R7 R2 contents kept, read while disabled");
        rd_chk(6, "R7 R2 contents kept, read while disabled");

        // random mix against the model
        send_ext(2'b11);
        for (int n = 0; n < 40; n++) begin
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            int kind;
            a = AW'($urandom % NW);
            d = DW'($urandom);
            kind = int'($urandom % 3);
            if (kind == 0) begin
                prog(2'b01, a, d, 1, 1, "R3 random WRITE");
                model[a] = d;
            end else if (kind == 1) begin
                prog(2'b11, a, '0, 0, 1, "R4 random ERASE");
                model[a] = '1;
            end else begin
                rd_chk(a, "R2 random READ");
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule